// File: doc/BRIEF.md
# Multi-format ADC input conditioner

This block sits at the head of one downconversion channel. It picks one of several raw sample ports through a crossbar selector and rewrites the chosen word into a single 19-bit two's complement value that the mixer and filters downstream can consume, whatever the converter delivered. Four word formats are understood: 14-bit and 16-bit fixed point, a floating-point word made of a 12-bit mantissa and a 3-bit unsigned exponent, and the same floating-point word carrying two channels interleaved on alternate clocks.

Fixed-point words may arrive in offset binary. A configuration bit flips their top bit to turn them into two's complement. Floating-point words are denormalised by an arithmetic right shift of the MSB-aligned mantissa, by as many places as the exponent gives. A zero-pad option lets the block run from a clock faster than the sample rate: idle clocks produce zero samples flagged valid, so downstream logic sees a sample on every clock. All configuration is static and comes in on plain input pins. The result is registered one clock after the sample.

Top module: `adc_input_conditioner`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `out_valid` is 0 and `out_data` is 0.
- R2: A sample accepted at a rising clock edge appears on `out_data`, with `out_valid` high, right after that same edge. The latency is exactly one clock, and every accepted sample produces exactly one output.
- R3: With `cfg_mode` = 0 (14-bit fixed), port bits [13:0] go to `out_data[18:5]` and `out_data[4:0]` is 0.
- R4: With `cfg_mode` = 1 (16-bit fixed), port bits [15:0] go to `out_data[18:3]` and `out_data[2:0]` is 0.
- R5: In the two fixed-point modes, `cfg_msb_inv` = 1 inverts the top bit of the input word (bit 13 or bit 15) before placement.
- R6: With `cfg_mode` = 2 (floating point), the mantissa is port bits [11:0] in two's complement and the exponent is bits [14:12], unsigned. The output equals the mantissa placed in `out_data[18:7]` and then shifted right arithmetically by the exponent, which is the same as mantissa × 2^(7−exponent). Bit 15 and `cfg_msb_inv` have no effect.
- R7: `cfg_port_sel` values 0, 1, 2 and 3 select port A, B, C and D. Port A is `port_data[15:0]` and each next port is the next 16 bits up.
- R8: With `cfg_mode` = 3 (interleaved floating point), words are decoded as in R6. `in_phase` = 1 marks a lane-0 word and `in_phase` = 0 marks a lane-1 word. A strobed word is accepted only if its lane equals `cfg_lane_sel`. A strobed word of the other lane gives `out_valid` = 0.
- R9: When `in_strobe` is low and `cfg_zero_pad` is 1, the next output is 0 with `out_valid` = 1, in every mode.
- R10: When `in_strobe` is low and `cfg_zero_pad` is 0, `out_valid` goes low and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_data | input | 64 | Four 16-bit input ports; port A in bits [15:0] |
| in_strobe | input | 1 | High when the ports carry a new sample |
| in_phase | input | 1 | Interleaved mode: 1 = lane-0 word, 0 = lane-1 word |
| cfg_mode | input | 2 | 0 fixed 14, 1 fixed 16, 2 float, 3 interleaved float |
| cfg_port_sel | input | 2 | Crossbar port select, 0 = A … 3 = D |
| cfg_lane_sel | input | 1 | Interleaved lane this channel keeps |
| cfg_msb_inv | input | 1 | Offset-binary correction for fixed-point words |
| cfg_zero_pad | input | 1 | Emit zero samples on clocks without a strobe |
| out_data | output | 19 | Conditioned two's complement sample |
| out_valid | output | 1 | `out_data` carries a sample |

## Verification
The properties compare each clock's configuration and strobe with the next clock's output. They therefore assume that the configuration pins are never X and change only when the clock edge is taken as a whole, never partway through the setup of a sample. The stimulus meets this by updating configuration only on an idle clock, away from the rising edge, and in the same step it queues the zero that the idle clock produces when zero-pad is on. Expected words come from a separate model of each format, so exponent extremes, most-negative mantissas and the top-bit flip are judged against arithmetic and not against the design's own shifter.

// File: rtl/aic_pkg.sv
// Shared definitions for the ADC input conditioner.
// Assumes: the format code is a two-bit field driven from static configuration.
package aic_pkg;

    typedef enum logic [1:0] {
        FMT_FIX_NARROW = 2'd0,
        FMT_FIX_WIDE   = 2'd1,
        FMT_FLOAT      = 2'd2,
        FMT_FLOAT_IL   = 2'd3
    } fmt_e;

endpackage

// File: rtl/aic_port_mux.sv
// Crossbar leg: selects one input port out of a flat bus of equal-width ports.
// Assumes: port 0 occupies the least significant slice; a select beyond the
// last port yields zero.
module aic_port_mux #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 16,
    parameter int SEL_W     = 2
) (
    input  logic [NUM_PORTS*PORT_W-1:0] ports_flat,
    input  logic [SEL_W-1:0]            sel,
    output logic [PORT_W-1:0]           word
);

    logic [PORT_W-1:0] port_arr [NUM_PORTS];

    // Unpack the flat bus into one slice per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
        assign port_arr[p] = ports_flat[p*PORT_W +: PORT_W];
    end

    // Pick the addressed slice; out-of-range selects read as zero.
    always_comb begin
        word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel == SEL_W'(p)) begin
                word = port_arr[p];
            end
        end
    end

endmodule

// File: rtl/aic_formatter.sv
// Combinational format converter: turns one raw port word into the common
// MSB-aligned two's complement output word.
// Assumes: OUT_W exceeds both fixed widths, and the zero padding below the
// aligned mantissa is at least as wide as the largest exponent, so no shift
// drops a set bit.
module aic_formatter
    import aic_pkg::*;
#(
    parameter int PORT_W   = 16,
    parameter int NARROW_W = 14,
    parameter int OUT_W    = 19,
    parameter int MANT_W   = 12,
    parameter int EXP_W    = 3
) (
    input  logic [PORT_W-1:0] word,
    input  fmt_e              fmt,
    input  logic              msb_inv,
    output logic [OUT_W-1:0]  conv
);

    localparam int WIDE_W     = PORT_W;
    localparam int NARROW_PAD = OUT_W - NARROW_W;
    localparam int WIDE_PAD   = OUT_W - WIDE_W;
    localparam int FLT_PAD    = OUT_W - MANT_W;

    logic [NARROW_W-1:0]     narrow_w;
    logic [WIDE_W-1:0]       wide_w;
    logic [MANT_W-1:0]       mant;
    logic [EXP_W-1:0]        expo;
    logic signed [OUT_W-1:0] flt_aligned;
    logic [OUT_W-1:0]        narrow_out;
    logic [OUT_W-1:0]        wide_out;
    logic [OUT_W-1:0]        flt_out;

    // Fixed-point paths: optional top-bit flip for offset-binary sources.
    always_comb begin
        narrow_w = word[NARROW_W-1:0];
        narrow_w[NARROW_W-1] = narrow_w[NARROW_W-1] ^ msb_inv;
        wide_w = word[WIDE_W-1:0];
        wide_w[WIDE_W-1] = wide_w[WIDE_W-1] ^ msb_inv;
        narrow_out = {narrow_w, {NARROW_PAD{1'b0}}};
        wide_out   = {wide_w, {WIDE_PAD{1'b0}}};
    end

    // Floating-point path: align mantissa to the top, then shift down by exponent.
    always_comb begin
        mant        = word[MANT_W-1:0];
        expo        = word[MANT_W+EXP_W-1:MANT_W];
        flt_aligned = $signed({mant, {FLT_PAD{1'b0}}});
        flt_out     = OUT_W'(flt_aligned >>> expo);
    end

    // Choose the path that matches the configured format.
    always_comb begin
        unique case (fmt)
            FMT_FIX_NARROW: conv = narrow_out;
            FMT_FIX_WIDE:   conv = wide_out;
            default:        conv = flt_out;
        endcase
    end

endmodule

// File: rtl/aic_out_stage.sv
// Output register: qualifies samples by strobe and interleave lane, inserts
// zero samples when zero-pad is on, and holds the last word otherwise.
// Assumes: configuration is stable around each clock edge.
module aic_out_stage
    import aic_pkg::*;
#(
    parameter int OUT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] conv,
    input  fmt_e             fmt,
    input  logic             strobe,
    input  logic             phase,
    input  logic             lane_sel,
    input  logic             zero_pad,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid
);

    logic lane_ok;
    logic take;
    logic pad;

    // Decide whether this clock carries a kept sample or a padding zero.
    always_comb begin
        lane_ok = (fmt != FMT_FLOAT_IL) || (phase ^ lane_sel);
        take    = strobe && lane_ok;
        pad     = !strobe && zero_pad;
    end

    // Register the result with one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else if (take) begin
            out_data  <= conv;
            out_valid <= 1'b1;
        end else if (pad) begin
            out_data  <= '0;
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_input_conditioner.sv
// Top: routes one port through the crossbar, converts it to the common
// 19-bit word and registers it.
// Assumes: configuration pins are static during a run of samples.
module adc_input_conditioner
    import aic_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 16,
    parameter int NARROW_W  = 14,
    parameter int MANT_W    = 12,
    parameter int EXP_W     = 3,
    parameter int OUT_W     = 19,
    parameter int SEL_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] port_data,
    input  logic                        in_strobe,
    input  logic                        in_phase,
    input  logic [1:0]                  cfg_mode,
    input  logic [SEL_W-1:0]            cfg_port_sel,
    input  logic                        cfg_lane_sel,
    input  logic                        cfg_msb_inv,
    input  logic                        cfg_zero_pad,
    output logic [OUT_W-1:0]            out_data,
    output logic                        out_valid
);

    fmt_e              fmt;
    logic [PORT_W-1:0] sel_word;
    logic [OUT_W-1:0]  conv;

    // Interpret the raw mode pins as a format code.
    assign fmt = fmt_e'(cfg_mode);

    aic_port_mux #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .SEL_W     (SEL_W)
    ) u_mux (
        .ports_flat (port_data),
        .sel        (cfg_port_sel),
        .word       (sel_word)
    );

    aic_formatter #(
        .PORT_W   (PORT_W),
        .NARROW_W (NARROW_W),
        .OUT_W    (OUT_W),
        .MANT_W   (MANT_W),
        .EXP_W    (EXP_W)
    ) u_fmt (
        .word    (sel_word),
        .fmt     (fmt),
        .msb_inv (cfg_msb_inv),
        .conv    (conv)
    );

    aic_out_stage #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv      (conv),
        .fmt       (fmt),
        .strobe    (in_strobe),
        .phase     (in_phase),
        .lane_sel  (cfg_lane_sel),
        .zero_pad  (cfg_zero_pad),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/aic_checker.sv
// Port-level properties for the input conditioner, bound to the top.
// Assumes: configuration pins are known and applied whole at each edge.
module aic_checker #(
    parameter int OUT_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_strobe,
    input logic             in_phase,
    input logic [1:0]       cfg_mode,
    input logic             cfg_lane_sel,
    input logic             cfg_zero_pad,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid
);

    // R3
    narrow_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && in_strobe) |=> (out_valid && out_data[4:0] == 5'd0));

    // R4
    wide_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && in_strobe) |=> (out_valid && out_data[2:0] == 3'd0));

    // R2
    float_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && in_strobe) |=> out_valid);

    // R8
    other_lane_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && in_strobe && (in_phase == cfg_lane_sel)) |=> !out_valid);

    // R9
    zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_strobe && cfg_zero_pad) |=> (out_valid && out_data == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_strobe && !cfg_zero_pad) |=> (!out_valid && $stable(out_data)));

endmodule

bind adc_input_conditioner aic_checker #(.OUT_W(OUT_W)) u_aic_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_strobe    (in_strobe),
    .in_phase     (in_phase),
    .cfg_mode     (cfg_mode),
    .cfg_lane_sel (cfg_lane_sel),
    .cfg_zero_pad (cfg_zero_pad),
    .out_data     (out_data),
    .out_valid    (out_valid)
);

// File: tb/test_adc_input_conditioner.sv
// Scoreboard bench: the driver queues expected words, the monitor checks them.
module test_adc_input_conditioner;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] port_data;
    logic        in_strobe;
    logic        in_phase;
    logic [1:0]  cfg_mode;
    logic [1:0]  cfg_port_sel;
    logic        cfg_lane_sel;
    logic        cfg_msb_inv;
    logic        cfg_zero_pad;
    logic [18:0] out_data;
    logic        out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [18:0] exp_q [$];
    string       tag_q [$];
    logic [18:0] last_exp = '0;

    always #4 clk = ~clk;   // 125 MHz

    adc_input_conditioner i_adc_input_conditioner (
        .clk (clk), .rst_n (rst_n), .port_data (port_data),
        .in_strobe (in_strobe), .in_phase (in_phase), .cfg_mode (cfg_mode),
        .cfg_port_sel (cfg_port_sel), .cfg_lane_sel (cfg_lane_sel),
        .cfg_msb_inv (cfg_msb_inv), .cfg_zero_pad (cfg_zero_pad),
        .out_data (out_data), .out_valid (out_valid)
    );

    function automatic logic [18:0] model(logic [15:0] w, logic [1:0] m, logic inv);
        logic [13:0]        n;
        logic [15:0]        v;
        logic signed [18:0] s;
        n = w[13:0];
        v = w;
        if (inv) begin
            n[13] = ~n[13];
            v[15] = ~v[15];
        end
        s = {{7{w[11]}}, w[11:0]};
        case (m)
            2'd0:    return {n, 5'd0};
            2'd1:    return {v, 3'd0};
            default: return 19'(s <<< (3'd7 - w[14:12]));
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [18:0] act, logic [18:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Apply a new configuration on an idle clock.
    task automatic set_cfg(logic [1:0] m, logic [1:0] sel, logic lane, logic inv, logic zp);
        @(negedge clk);
        cfg_mode = m; cfg_port_sel = sel; cfg_lane_sel = lane;
        cfg_msb_inv = inv; cfg_zero_pad = zp; in_strobe = 1'b0;
        if (zp) begin
            exp_q.push_back('0); tag_q.push_back("R9");
            last_exp = '0;
        end
    endtask

    // Drive one clock of port data and queue what it should produce.
    task automatic drv(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d,
                       logic stb, logic ph, string tag);
        logic [15:0] w;
        @(negedge clk);
        port_data = {d, c, b, a};
        in_strobe = stb;
        in_phase  = ph;
        case (cfg_port_sel)
            2'd0: w = a;
            2'd1: w = b;
            2'd2: w = c;
            default: w = d;
        endcase
        if (stb && (cfg_mode != 2'd3 || (ph ^ cfg_lane_sel))) begin
            last_exp = model(w, cfg_mode, cfg_mode[1] ? 1'b0 : cfg_msb_inv);
            exp_q.push_back(last_exp); tag_q.push_back(tag);
        end else if (!stb && cfg_zero_pad) begin
            last_exp = '0;
            exp_q.push_back('0); tag_q.push_back("R9");
        end
    endtask

    // Monitor: every valid output must match the oldest queued word.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected", out_data, '0);
            end else begin
                logic [18:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data === e, t, out_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", '0, '0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; port_data = '0; in_strobe = 1'b0; in_phase = 1'b0;
        cfg_mode = 2'd0; cfg_port_sel = 2'd0; cfg_lane_sel = 1'b0;
        cfg_msb_inv = 1'b0; cfg_zero_pad = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && out_data == '0, "R1", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && out_data == '0, "R1", out_data, '0);

        // R3 / R7: 14-bit words from every port, sign extremes included
        for (int p = 0; p < 4; p++) begin
            set_cfg(2'd0, 2'(p), 1'b0, 1'b0, 1'b0);
            drv(16'h2000, 16'h1FFF, 16'h0ABC, 16'h3333, 1'b1, 1'b0, "R7");
            drv(16'hC123, 16'h0001, 16'h3FFF, 16'h2001, 1'b1, 1'b0, "R3");
        end
        // R5: offset-binary flip on 14 bits
        set_cfg(2'd0, 2'd1, 1'b0, 1'b1, 1'b0);
        drv(16'h0, 16'h2000, 16'h0, 16'h0, 1'b1, 1'b0, "R5");
        drv(16'h0, 16'h1FFF, 16'h0, 16'h0, 1'b1, 1'b0, "R5");

        // R4 / R7 / R5: 16-bit words
        for (int p = 0; p < 3; p++) begin
            set_cfg(2'd1, 2'(p), 1'b0, 1'b0, 1'b0);
            drv(16'h8000, 16'h7FFF, 16'hFFFF, 16'h1234, 1'b1, 1'b0, "R4");
        end
        set_cfg(2'd1, 2'd2, 1'b0, 1'b1, 1'b0);
        drv(16'h0, 16'h0, 16'h8000, 16'h0, 1'b1, 1'b0, "R5");
        drv(16'h0, 16'h0, 16'h0123, 16'h0, 1'b1, 1'b0, "R5");

        // R6: every exponent with extreme and ordinary mantissas, bit 15 set
        set_cfg(2'd2, 2'd0, 1'b0, 1'b1, 1'b0);
        for (int e = 0; e < 8; e++) begin
            drv({4'b0, 12'h800} | 16'(e << 12), 16'h0, 16'h0, 16'h0, 1'b1, 1'b0, "R6");
            drv({4'b0, 12'h7FF} | 16'(e << 12), 16'h0, 16'h0, 16'h0, 1'b1, 1'b0, "R6");
            drv({4'b1000, 12'hA5C} | 16'(e << 12), 16'h0, 16'h0, 16'h0, 1'b1, 1'b0, "R6");
        end

        // R8: interleaved lanes, each lane selection
        for (int l = 0; l < 2; l++) begin
            set_cfg(2'd3, 2'd2, 1'(l), 1'b0, 1'b0);
            for (int k = 0; k < 6; k++) begin
                drv(16'h0, 16'h0, 16'((k * 16'h1357) ^ 16'h0801), 16'h0,
                    1'b1, 1'(k % 2 == 0), "R8");
            end
        end

        // R9: zero padding between strobes, fixed and float modes
        set_cfg(2'd0, 2'd3, 1'b0, 1'b0, 1'b1);
        drv(16'h0, 16'h0, 16'h0, 16'h1555, 1'b1, 1'b0, "R9");
        drv(16'h0, 16'h0, 16'h0, 16'h1555, 1'b0, 1'b0, "R9");
        drv(16'h0, 16'h0, 16'h0, 16'h1555, 1'b0, 1'b0, "R9");
        set_cfg(2'd3, 2'd0, 1'b1, 1'b0, 1'b1);
        drv(16'h4321, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1, "R8");
        drv(16'h4321, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R9");

        // R10: no strobe, no padding -> valid low, data held
        set_cfg(2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
        drv(16'h0, 16'hBEEF, 16'h0, 16'h0, 1'b1, 1'b0, "R4");
        drv(16'h0, 16'h1111, 16'h0, 16'h0, 1'b0, 1'b0, "R10");
        @(negedge clk);
        check(!out_valid && out_data == last_exp, "R10", out_data, last_exp);
        @(negedge clk);
        check(!out_valid && out_data == last_exp, "R10", out_data, last_exp);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 missing", 19'(exp_q.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule